// File: doc/BRIEF.md
# RSSI Averager and Clear-Channel Decision

This block smooths a stream of per-sample signal levels with a first-order leaky integrator and turns the smoothed level into a calibrated 8-bit signal-strength code. It also decides whether the channel is busy by comparing that code against a programmable threshold. The smoothing constant can be switched between one symbol period and a quarter of a symbol period. A slow constant gives a steadier reading. A fast constant follows the input sooner but varies more.

Each input sample is a 7-bit level in dB steps, where level L stands for L−127 dBm. The integrator keeps fractional bits below that scale. A signed 6-bit calibration offset is added to the integer part of the average at wider precision, and the sum is clamped to 0..127. The code and the busy decision are frozen into the status outputs only when the receive path signals the end of a packet or the end of an energy/clear-channel measurement. A valid pulse follows each capture by one cycle.

Top module: `rssi_cca`

## Requirements
- R1: After reset the held code is 0, the busy flag and the valid pulse are low, the threshold is 0xFF, the offset is 0 and the slow constant is selected.
- R2: On each cycle with `smp_vld` high in slow mode, the accumulator (level scaled by 2^SYM_LOG2) moves by (level·2^SYM_LOG2 − acc) arithmetically shifted right by SYM_LOG2. It holds its value when `smp_vld` is low.
- R3: With the fast constant loaded (`cfg_fast`=1), the shift becomes SYM_LOG2−2, a quarter of the symbol constant.
- R4: The code is the integer part of the accumulator plus the two's-complement offset (−32..+31). A negative sum gives 0 and never wraps.
- R5: A sum above 127 gives 127, so bit 7 of the held code is always 0.
- R6: The busy flag is set only when the captured code is strictly greater than the threshold. With the reset threshold 0xFF the channel is never busy.
- R7: The held code and the busy flag change only on the edge that samples `cap_stb` high. Samples with no strobe leave them untouched.
- R8: `cap_vld` is high for exactly the cycle after each cycle with `cap_stb` high. Back-to-back strobes give back-to-back pulses.
- R9: A strobe in the same cycle as a sample captures the accumulator as it was before that sample.
- R10: A one-cycle `cfg_ld` loads the threshold, the offset and the constant select together. They take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | A level sample is present |
| smp_lvl | input | 7 | Sample level, L means L−127 dBm |
| cfg_ld | input | 1 | Load the configuration fields |
| cfg_thr | input | 8 | Busy threshold |
| cfg_ofs | input | 6 | Signed calibration offset in dB |
| cfg_fast | input | 1 | 1 selects the quarter-symbol constant |
| cap_stb | input | 1 | End of packet or end of measurement |
| rssi_hold | output | 8 | Captured signal-strength code |
| chan_busy | output | 1 | Captured busy decision |
| cap_vld | output | 1 | One-cycle pulse after a capture |

## Verification
The bench targets the following corner cases, and states what a faulty design would show for each:

- **Offset at both extremes.** A −32 offset on a low level must give 0; a design that wraps would report a code near 96 or above. A +31 offset on a high level must give 127; a wrap would give a small code.
- **Threshold equal to the code.** A threshold exactly equal to the code must leave the channel clear, and one below it must mark it busy. A non-strict comparison flips the first case.
- **Strobe coinciding with a sample.** The capture must show the value from before the update; a design that captures after the update shows a larger code.
- **Reset threshold and idle samples.** A reset threshold other than 0xFF would flag a strong signal as busy. A filter that keeps integrating while `smp_vld` is low would drift the captured code.
- **Fast versus slow shift.** A wrong shift in fast mode produces a different trajectory from the bench model after only a few samples.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
  localparam int LVL_W    = 7;
  localparam int OFS_W    = 6;
  localparam int CODE_W   = 8;
  localparam int CODE_MAX = 127;

  // Integer level plus signed offset, widened before the clamp to 0..CODE_MAX.
  function automatic logic [CODE_W-1:0] map_code(input logic [LVL_W-1:0] lvl,
                                                 input logic [OFS_W-1:0] ofs);
    logic signed [LVL_W+1:0] sum;
    sum = $signed({2'b00, lvl}) + $signed({{(LVL_W+2-OFS_W){ofs[OFS_W-1]}}, ofs});
    if (sum < 0)
      return '0;
    else if (sum > CODE_MAX)
      return CODE_W'(CODE_MAX);
    else
      return {1'b0, sum[LVL_W-1:0]};
  endfunction
endpackage

// File: rtl/rssi_leaky_filter.sv
module rssi_leaky_filter #(
  parameter int LVL_W    = 7,
  parameter int SYM_LOG2 = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_vld,
  input  logic [LVL_W-1:0]          smp_lvl,
  input  logic                      fast,
  output logic [LVL_W+SYM_LOG2-1:0] acc
);
  localparam int AW         = LVL_W + SYM_LOG2;
  localparam int SLOW_SHIFT = SYM_LOG2;
  localparam int FAST_SHIFT = SYM_LOG2 - 2;

  logic signed [AW:0] diff, step, nxt;

  always_comb begin
    diff = $signed({1'b0, smp_lvl, {SYM_LOG2{1'b0}}}) - $signed({1'b0, acc});
    step = fast ? (diff >>> FAST_SHIFT) : (diff >>> SLOW_SHIFT);
    nxt  = $signed({1'b0, acc}) + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (smp_vld) acc <= nxt[AW-1:0];
  end

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(acc)); // R2
  AST_ACC_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && ({1'b0, smp_lvl, {SYM_LOG2{1'b0}}} >= {1'b0, acc}))
      |=> (acc <= {$past(smp_lvl), {SYM_LOG2{1'b0}}})); // R3
endmodule

// File: rtl/rssi_cca.sv
module rssi_cca
  import rssi_pkg::*;
#(
  parameter int SYM_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [LVL_W-1:0]  smp_lvl,
  input  logic              cfg_ld,
  input  logic [CODE_W-1:0] cfg_thr,
  input  logic [OFS_W-1:0]  cfg_ofs,
  input  logic              cfg_fast,
  input  logic              cap_stb,
  output logic [CODE_W-1:0] rssi_hold,
  output logic              chan_busy,
  output logic              cap_vld
);
  localparam int AW = LVL_W + SYM_LOG2;

  logic [CODE_W-1:0] thr_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              fast_q;
  logic [AW-1:0]     acc;
  logic [CODE_W-1:0] code_now;
  logic              busy_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '1;
      ofs_q  <= '0;
      fast_q <= 1'b0;
    end else if (cfg_ld) begin
      thr_q  <= cfg_thr;
      ofs_q  <= cfg_ofs;
      fast_q <= cfg_fast;
    end
  end

  rssi_leaky_filter #(.LVL_W(LVL_W), .SYM_LOG2(SYM_LOG2)) u_filt (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_lvl(smp_lvl),
    .fast(fast_q), .acc(acc)
  );

  assign code_now = map_code(acc[AW-1:SYM_LOG2], ofs_q);
  assign busy_now = (code_now > thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rssi_hold <= '0;
      chan_busy <= 1'b0;
      cap_vld   <= 1'b0;
    end else begin
      cap_vld <= cap_stb;
      if (cap_stb) begin
        rssi_hold <= code_now;
        chan_busy <= busy_now;
      end
    end
  end

  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> cap_vld); // R8
  AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> !cap_vld); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> ($stable(rssi_hold) && $stable(chan_busy))); // R7
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_hold[CODE_W-1] == 1'b0); // R5
  AST_BUSY_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |-> (chan_busy == (rssi_hold > $past(thr_q)))); // R6
endmodule

// File: tb/sim_rssi_cca.sv
module sim_rssi_cca;
  localparam int CLK_PERIOD = 10;
  localparam int SYM = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_vld = 1'b0;
  logic [6:0] smp_lvl = '0;
  logic       cfg_ld = 1'b0;
  logic [7:0] cfg_thr = '0;
  logic [5:0] cfg_ofs = '0;
  logic       cfg_fast = 1'b0;
  logic       cap_stb = 1'b0;
  logic [7:0] rssi_hold;
  logic       chan_busy;
  logic       cap_vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  int m_acc = 0, m_thr = 255, m_ofs = 0, m_fast = 0;
  int exp_q[$];   // packed as code*2 + busy

  always #(CLK_PERIOD/2) clk = ~clk;

  rssi_cca #(.SYM_LOG2(SYM)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_lvl(smp_lvl),
    .cfg_ld(cfg_ld), .cfg_thr(cfg_thr), .cfg_ofs(cfg_ofs), .cfg_fast(cfg_fast),
    .cap_stb(cap_stb), .rssi_hold(rssi_hold), .chan_busy(chan_busy), .cap_vld(cap_vld)
  );

  function automatic int model_code();
    int v;
    v = (m_acc / (1 << SYM)) + m_ofs;
    if (v < 0) v = 0;
    if (v > 127) v = 127;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus, model updated alongside
  task automatic step(input bit vld, input int lvl, input bit stb);
    int diff, c;
    smp_vld = vld; smp_lvl = 7'(lvl); cap_stb = stb;
    if (stb) begin
      c = model_code();
      exp_q.push_back(c * 2 + ((c > m_thr) ? 1 : 0));
    end
    if (vld) begin
      diff = lvl * (1 << SYM) - m_acc;
      m_acc = m_acc + (diff >>> (m_fast ? SYM - 2 : SYM));
    end
    @(negedge clk);
    smp_vld = 1'b0; cap_stb = 1'b0;
  endtask

  task automatic feed(input int n, input int lvl);
    for (int i = 0; i < n; i++) step(1'b1, lvl, 1'b0);
  endtask

  task automatic capture();
    step(1'b0, 0, 1'b1);
    @(negedge clk);
  endtask

  task automatic cfg(input int thr, input int ofs, input int fast);
    cfg_ld = 1'b1; cfg_thr = 8'(thr); cfg_ofs = 6'(ofs); cfg_fast = 1'(fast);
    @(negedge clk);
    cfg_ld = 1'b0;
    m_thr = thr; m_ofs = ofs; m_fast = fast;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cap_vld && !done) begin
      if (exp_q.size() == 0) begin
        chk("R8 stray valid", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk("R2/R4 captured code", int'(rssi_hold), e / 2);
        chk("R6 busy", int'(chan_busy), e % 2);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk("R1 reset code", int'(rssi_hold), 0);
    chk("R1 reset busy", int'(chan_busy), 0);
    chk("R1 reset valid", int'(cap_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    capture();                          // R1: zero code, threshold FF
    // R2 slow filter, R6 default threshold never busy
    feed(60, 100);
    capture();
    // R2 idle cycles leave accumulator untouched
    repeat (10) step(1'b0, 5, 1'b0);
    capture();
    // R7 samples without strobe do not move the held code
    held = int'(rssi_hold);
    feed(20, 3);
    chk("R7 hold stable", int'(rssi_hold), held);
    chk("R8 no valid without strobe", int'(cap_vld), 0);
    // R10/R3 fast constant with threshold 50
    cfg(50, 0, 1);
    feed(6, 90);
    capture();
    feed(3, 10);
    capture();
    // R9 strobe together with a sample captures pre-update value
    feed(10, 120);
    step(1'b1, 0, 1'b1);
    @(negedge clk);
    capture();
    // R4 low clamp: level near zero, offset -32
    feed(30, 2);
    cfg(255, -32, 0);
    capture();
    // R5 high clamp: level 127, offset +31
    feed(80, 127);
    cfg(0, 31, 0);
    capture();
    chk("R5 msb clear", int'(rssi_hold[7]), 0);
    // R6 threshold equal to code is not busy, one below is busy
    cfg(255, 0, 0);
    cfg(model_code(), 0, 0);
    capture();
    cfg(model_code() - 1, 0, 0);
    capture();
    // R8 back-to-back strobes
    step(1'b1, 40, 1'b1);
    step(1'b1, 40, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R8 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule